// File: doc/BRIEF.md
# Deficit Round Robin Packet Scheduler

This block chooses which of several per-flow packet queues may send next on a shared output link. It serves variable-length packets fairly, and it can weight flows against each other. Each decision costs a fixed amount of work, however many flows there are. The queue storage sits outside the block. For every queue the storage presents a busy flag, meaning the queue holds at least one packet, and the byte length of the packet at its head. Each queue also has a quantum of byte credit, supplied on an input bus.

A pointer visits the queues in ascending index order and wraps from the last queue back to queue 0. Each visit to a busy queue adds that queue's quantum to its deficit counter. While the head packet fits within the deficit, the block offers a grant carrying the queue index and the packet length. When the grant is accepted, the length is charged against the deficit and the storage pops the packet. When the head packet is longer than the deficit, the pointer moves on and the leftover credit stays with the queue. A queue found empty loses its credit. The pointer examines one queue per clock cycle.

Top module: `drr_sched`

## Requirements
- R1: When the pointer reaches a busy queue, that queue's deficit increases by exactly its quantum, once per visit.
- R2: During a visit, the queue is granted head packets for as long as each head length is less than or equal to its deficit. Each accepted grant lowers the deficit by the granted length. The packets of one queue are granted in order, and a grant is only ever offered for a busy queue.
- R3: Each queue uses its own quantum, taken from bits [i*LEN_W +: LEN_W] of `quantum` for queue i. The grant order therefore follows the per-queue credit rates.
- R4: When the pointer finds a queue empty, that queue's deficit becomes zero. A packet that later arrives in that queue starts from no leftover credit.
- R5: The pointer skips empty queues without giving them credit and without offering a grant. Visits go in ascending index order and wrap from NQ-1 to 0. With every queue empty, `grant_valid` stays low.
- R6: A head packet longer than the deficit stays unsent, and the deficit carries over to the next visit. With a quantum of 200, a 600-byte head packet is granted on the third visit to its queue.
- R7: While `grant_valid` is high and `grant_ready` is low, `grant_valid`, `grant_queue` and `grant_len` hold steady. A grant counts as accepted only in a cycle where both are high.
- R8: During reset `grant_valid` is low. After reset, every deficit is zero and the first visit is to queue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_busy | input | NQ | Bit i high when queue i holds at least one packet |
| head_len | input | NQ*LEN_W | Head packet length of queue i in bits [i*LEN_W +: LEN_W] |
| quantum | input | NQ*LEN_W | Per-round byte credit of queue i in bits [i*LEN_W +: LEN_W] |
| grant_valid | output | 1 | A dequeue grant is offered |
| grant_ready | input | 1 | The dequeue side accepts the offered grant |
| grant_queue | output | QI_W | Index of the queue to dequeue |
| grant_len | output | LEN_W | Length of the packet being dequeued |

## Verification
The bench targets a 600-byte head packet behind a 200-byte quantum, packets whose length exactly equals the deficit, and a queue that drains and later refills. A design that lets credit survive an empty queue would send the refilled packet one round early. A design that uses "less than" instead of "less or equal" in the fit test would hold back exact-fit packets. A design that credited empty queues, or kept credit it should have charged, would reorder grants against the arithmetic round model. Back-pressure on `grant_ready` is varied throughout, so a grant that drifts or repeats while stalled shows up as a wrong or extra grant.

// File: rtl/drr_sched.sv
module drr_sched #(
  parameter int NQ    = 4,
  parameter int LEN_W = 10,
  localparam int QI_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int DEF_W = LEN_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       q_busy,
  input  logic [NQ*LEN_W-1:0] head_len,
  input  logic [NQ*LEN_W-1:0] quantum,
  output logic                grant_valid,
  input  logic                grant_ready,
  output logic [QI_W-1:0]     grant_queue,
  output logic [LEN_W-1:0]    grant_len
);

  logic [DEF_W-1:0] deficit [NQ];
  logic [QI_W-1:0]  ptr;
  logic             serving;

  logic [LEN_W-1:0] cur_len, cur_quant;
  logic             cur_busy, fits;
  logic [QI_W-1:0]  ptr_nx;

  assign cur_len   = head_len[ptr*LEN_W +: LEN_W];
  assign cur_quant = quantum[ptr*LEN_W +: LEN_W];
  assign cur_busy  = q_busy[ptr];
  assign fits      = {1'b0, cur_len} <= deficit[ptr];
  assign ptr_nx    = (ptr == QI_W'(NQ-1)) ? '0 : ptr + 1'b1;

  assign grant_valid = serving && cur_busy && fits;
  assign grant_queue = ptr;
  assign grant_len   = cur_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      serving <= 1'b0;
      for (int i = 0; i < NQ; i++) deficit[i] <= '0;
    end else if (!serving) begin
      if (cur_busy) begin
        deficit[ptr] <= deficit[ptr] + {1'b0, cur_quant};
        serving      <= 1'b1;
      end else begin
        deficit[ptr] <= '0;
        ptr          <= ptr_nx;
      end
    end else if (!cur_busy) begin
      deficit[ptr] <= '0;
      serving      <= 1'b0;
      ptr          <= ptr_nx;
    end else if (fits) begin
      if (grant_ready) deficit[ptr] <= deficit[ptr] - {1'b0, cur_len};
    end else begin
      serving <= 1'b0;
      ptr     <= ptr_nx;
    end
  end

endmodule

// File: rtl/drr_sched_chk.sv
module drr_sched_chk #(
  parameter int NQ    = 4,
  parameter int LEN_W = 10,
  localparam int QI_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int DEF_W = LEN_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NQ-1:0]       q_busy,
  input logic [NQ*LEN_W-1:0] quantum,
  input logic                grant_valid,
  input logic                grant_ready,
  input logic [QI_W-1:0]     grant_queue,
  input logic [LEN_W-1:0]    grant_len,
  input logic                serving,
  input logic [QI_W-1:0]     ptr,
  input logic [DEF_W-1:0]    deficit [NQ]
);

  logic [QI_W-1:0]  ptr_q;
  logic [DEF_W-1:0] def_q;
  logic [LEN_W-1:0] len_q, quant_q;

  always_ff @(posedge clk) begin
    ptr_q   <= ptr;
    def_q   <= deficit[ptr];
    len_q   <= grant_len;
    quant_q <= quantum[ptr*LEN_W +: LEN_W];
  end

  assert_credit_on_visit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!serving && q_busy[ptr]) |=> (serving && deficit[ptr_q] == def_q + {1'b0, quant_q}));

  assert_charge_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=> (deficit[ptr_q] == def_q - {1'b0, len_q}));

  assert_grant_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> q_busy[grant_queue]);

  assert_empty_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && !q_busy[ptr]) |=> (!serving && deficit[ptr_q] == '0));

  assert_skip_no_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!serving && !q_busy[ptr]) |=> (!serving && deficit[ptr_q] == '0 && !grant_valid));

  assert_hold_while_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_queue) && $stable(grant_len)));

endmodule

bind drr_sched drr_sched_chk #(.NQ(NQ), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_busy(q_busy), .quantum(quantum),
  .grant_valid(grant_valid), .grant_ready(grant_ready),
  .grant_queue(grant_queue), .grant_len(grant_len),
  .serving(serving), .ptr(ptr), .deficit(deficit)
);

// File: tb/tb_drr_sched.sv
`timescale 1ns/1ps
module tb_drr_sched;
  localparam int NQ = 4;
  localparam int LEN_W = 10;
  localparam int QI_W = 2;
  localparam int DEPTH = 32;
  localparam int MAXG = 160;

  logic                clk = 0;
  logic                rst_n = 0;
  logic [NQ-1:0]       q_busy = '0;
  logic [NQ*LEN_W-1:0] head_len = '0;
  logic [NQ*LEN_W-1:0] quantum = '0;
  logic                grant_valid;
  logic                grant_ready = 0;
  logic [QI_W-1:0]     grant_queue;
  logic [LEN_W-1:0]    grant_len;

  drr_sched #(.NQ(NQ), .LEN_W(LEN_W)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int quant [NQ];
  int bpk [NQ][DEPTH]; int btl [NQ];
  int pk [NQ][DEPTH];  int hd [NQ]; int tl [NQ];
  int push_k [8]; int push_q [8]; int push_len [8]; int n_push;
  int exp_q [MAXG]; int exp_len [MAXG]; int n_exp;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < NQ; i++) begin btl[i] = 0; quant[i] = 100; end
    n_push = 0;
  endtask

  task automatic add(input int q, input int len);
    bpk[q][btl[q]] = len; btl[q]++;
  endtask

  task automatic add_push(input int k, input int q, input int len);
    push_k[n_push] = k; push_q[n_push] = q; push_len[n_push] = len; n_push++;
  endtask

  task automatic apply_pushes(input int k);
    for (int p = 0; p < n_push; p++)
      if (push_k[p] == k) begin pk[push_q[p]][tl[push_q[p]]] = push_len[p]; tl[push_q[p]]++; end
  endtask

  task automatic load_live();
    for (int i = 0; i < NQ; i++) begin
      hd[i] = 0; tl[i] = btl[i];
      for (int j = 0; j < btl[i]; j++) pk[i][j] = bpk[i][j];
    end
  endtask

  task automatic drive_ports();
    for (int i = 0; i < NQ; i++) begin
      q_busy[i] = hd[i] < tl[i];
      head_len[i*LEN_W +: LEN_W] = (hd[i] < tl[i]) ? LEN_W'(pk[i][hd[i]]) : '0;
      quantum[i*LEN_W +: LEN_W] = LEN_W'(quant[i]);
    end
  endtask

  task automatic compute_model();
    int def [NQ]; int p; int guard; bit any;
    load_live();
    for (int i = 0; i < NQ; i++) def[i] = 0;
    n_exp = 0; p = 0; guard = 0;
    any = 1;
    while (any && guard < 4000) begin
      guard++;
      if (hd[p] < tl[p]) begin
        def[p] += quant[p];
        while (hd[p] < tl[p] && pk[p][hd[p]] <= def[p]) begin
          exp_q[n_exp] = p; exp_len[n_exp] = pk[p][hd[p]];
          def[p] -= pk[p][hd[p]]; hd[p]++;
          apply_pushes(n_exp);
          n_exp++;
        end
      end
      if (!(hd[p] < tl[p])) def[p] = 0;
      p = (p + 1) % NQ;
      any = 0;
      for (int i = 0; i < NQ; i++) if (hd[i] < tl[i]) any = 1;
    end
  endtask

  task automatic run_scenario(input string tag);
    int ng; int t0; bit hs; int gq;
    compute_model();
    load_live();
    @(negedge clk);
    rst_n = 0; grant_ready = 0;
    drive_ports();
    @(negedge clk);
    check(grant_valid == 1'b0, "R8 reset", grant_valid, 0);
    rst_n = 1;
    ng = 0; t0 = cyc;
    while (ng < n_exp && cyc - t0 < 20000) begin
      @(negedge clk);
      grant_ready = ((cyc * 7 + ng) % 5) != 0;
      hs = 0;
      if (grant_valid && grant_ready) begin
        check(int'(grant_queue) == exp_q[ng], {tag, " queue"}, grant_queue, exp_q[ng]);
        check(int'(grant_len) == exp_len[ng], {tag, " len"}, grant_len, exp_len[ng]);
        gq = grant_queue; hs = 1;
      end
      @(posedge clk); #1;
      if (hs) begin
        hd[gq]++;
        apply_pushes(ng);
        ng++;
        drive_ports();
      end
    end
    check(ng == n_exp, {tag, " R2 grant count"}, ng, n_exp);
    grant_ready = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(grant_valid == 1'b0, {tag, " R5 idle when all empty"}, grant_valid, 0);
    end
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 R2: equal quanta, exact-fit and fragmented packets, one empty queue
    clear_all();
    add(0, 60); add(0, 40); add(0, 100);
    add(1, 150); add(1, 50);
    add(3, 30); add(3, 30); add(3, 30); add(3, 30);
    run_scenario("R1 R2 basic");

    // R3: weighted quanta
    clear_all();
    quant[0] = 300; quant[1] = 200; quant[2] = 100; quant[3] = 100;
    for (int i = 0; i < NQ; i++) for (int j = 0; j < 6; j++) add(i, 100);
    run_scenario("R3 weights");

    // R6: 600-byte head behind a 200 quantum
    clear_all();
    for (int i = 0; i < NQ; i++) quant[i] = 200;
    add(0, 600); add(0, 100);
    for (int j = 0; j < 5; j++) add(1, 100);
    run_scenario("R6 oversized head");
    check(exp_q[4] == 0 && exp_len[4] == 600, "R6 model third visit", exp_len[4], 600);

    // R4 R5: drained queue refilled later must start from zero credit
    clear_all();
    add(0, 150);
    for (int j = 0; j < 6; j++) add(1, 100);
    add_push(2, 0, 140);
    run_scenario("R4 R5 refill");
    check(exp_q[3] == 1 && exp_q[4] == 0, "R4 model order", exp_q[4], 0);

    // R2 R3 R5: arithmetic sweep over quanta, lengths and one empty queue
    for (int s = 0; s < 4; s++) begin
      clear_all();
      for (int i = 0; i < NQ; i++) begin
        quant[i] = 64 * (s + 1) + 32 * i;
        if (i != s)
          for (int j = 0; j < 5 + (i + s) % 4; j++) add(i, (j * 37 + i * 53 + s * 11) % 300 + 1);
      end
      run_scenario("R2 R3 R5 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule